// File: doc/BRIEF.md
# Way-Predicted Set-Associative Read Cache

This block is the lookup side of a set-associative read cache that guesses, per set, which way the next access to that set will hit. On a new request only the guessed way's tag is compared. When that guess matches, the response follows one cycle later. When it does not match, the controller spends two more cycles comparing every tag in the set. That pass ends either in a slower hit or in a true miss.

A true miss raises a refill request carrying the line-aligned address and waits for the level below to return the whole line. The line is written into a way picked by least-recently-used order, with an empty way taken first. The response then carries the requested word with the hit flag low. Three counters separate fast hits, slow hits and misses, so the quality of the predictor can be read straight off the ports.

The processor side is a valid/ready request and a single-cycle response pulse. The refill side is a request level held until a one-cycle line return.

Top module: `wpred_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, `resp_valid` and `refill_req` are 0, all three counters read 0, and the first access to any address misses.
- R2: When the set's predicted way holds the requested tag, `resp_valid` rises exactly one cycle after the request is accepted, with `resp_hit`=1, and `cnt_fast` increments by one.
- R3: When the predicted way does not match but another way of the set does, `resp_valid` rises exactly three cycles after acceptance, with `resp_hit`=1, and `cnt_slow` increments by one.
- R4: After any hit, the set's prediction points at the way that hit, so an immediate repeat of that address is a one-cycle hit.
- R5: On a true miss, `refill_req` rises three cycles after acceptance with `refill_addr` equal to the request address with its 4 offset bits cleared. It stays high with that address until `refill_valid`. The response follows one cycle after `refill_valid`, with `resp_hit`=0 and data taken from `refill_line`, and `cnt_miss` increments by one.
- R6: A refill goes to the lowest-numbered invalid way of the set, or to the least-recently-used way if none is invalid. Hits and fills both count as uses. The set's prediction is set to the filled way.
- R7: `req_ready` is 0 from the cycle after a request that did not hit on its first compare until the cycle of its response, and is 1 in that response cycle.
- R8: A request accepted in the same cycle as a response is looked up with the prediction already updated by that response.
- R9: `resp_data` is 32-bit word number (address bits 3:2) of the 128-bit line, with word 0 at line bits 31:0.
- R10: Set index is address bits 9:4 and tag is bits 31:10. Prediction, replacement order and contents of one set are not changed by accesses to another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Byte address of the read |
| req_ready | output | 1 | Request accepted this cycle when valid |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | 1 for a hit, 0 for a response after refill |
| resp_data | output | 32 | Addressed word of the line |
| refill_req | output | 1 | Line fetch wanted from the level below |
| refill_addr | output | 32 | Line-aligned address of the fetch |
| refill_valid | input | 1 | Refill line present this cycle |
| refill_line | input | 128 | Returned line, word 0 in the low bits |
| cnt_fast | output | 16 | Count of first-compare hits |
| cnt_slow | output | 16 | Count of hits found on the full compare |
| cnt_miss | output | 16 | Count of true misses |

## Verification
The overlap that matters is a response retiring and a new lookup starting in the same cycle. The response writes the set's prediction and replacement order at the same clock edge that accepts the next request. The bench provokes this by making a line hit slowly, then issuing the same address in the very cycle its response appears. The second request must come back one cycle later as a fast hit. If it does not, the lookup read a stale prediction. Replacement order is judged the same way at the ports: the bench predicts from use history which line a fill evicts, then checks that exactly that line misses while its neighbour still hits.

// File: rtl/wpc_pkg.sv
// Package: shared controller state for the way-predicted cache.
// Assumes nothing beyond IEEE 1800-2017.
package wpc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE1 = 2'd1,
        ST_PROBE2 = 2'd2,
        ST_REFILL = 2'd3
    } wpc_state_e;
endpackage

// File: rtl/wpc_way_store.sv
// Tag, valid and line storage for all sets and ways.
// Port A compares one given way (the guess); port B compares all ways of a set.
// Assumes WAYS is 2 or 4; only valid bits are reset.
module wpc_way_store #(
    parameter int WAYS   = 2,
    parameter int SETS   = 64,
    parameter int TAG_W  = 22,
    parameter int LINE_W = 128,
    parameter int IDX_W  = 6,
    parameter int WIDX_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_set,
    input  logic [WIDX_W-1:0] a_way,
    input  logic [TAG_W-1:0]  a_tag,
    output logic              a_hit,
    output logic [LINE_W-1:0] a_line,
    input  logic [IDX_W-1:0]  b_set,
    input  logic [TAG_W-1:0]  b_tag,
    output logic [WAYS-1:0]   b_hit_vec,
    output logic [WAYS-1:0]   b_valid_vec,
    input  logic [WIDX_W-1:0] b_sel_way,
    output logic [LINE_W-1:0] b_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_set,
    input  logic [WIDX_W-1:0] wr_way,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line
);
    logic [WAYS-1:0]   valid_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [LINE_W-1:0] line_q  [SETS][WAYS];

    // Valid bits: cleared on reset, set by a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    // Tag and line payload: written by a fill, never reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            line_q[wr_set][wr_way] <= wr_line;
        end
    end

    // Guess compare: single way of the requested set.
    always_comb begin
        a_hit  = valid_q[a_set][a_way] && (tag_q[a_set][a_way] == a_tag);
        a_line = line_q[a_set][a_way];
    end

    // Full compare: one comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign b_hit_vec[w]   = valid_q[b_set][w] && (tag_q[b_set][w] == b_tag);
        assign b_valid_vec[w] = valid_q[b_set][w];
    end
    assign b_line = line_q[b_set][b_sel_way];

    // R6: a fill leaves the written way valid.
    p_fill_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_set)][$past(wr_way)]);
    // R4: the full compare never finds the same tag in two ways.
    p_tag_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(b_hit_vec));
endmodule

// File: rtl/wpc_pred_table.sv
// Per-set guess of the way the next access will hit.
// Assumes one update at most per cycle; reset points every set at way 0.
module wpc_pred_table #(
    parameter int SETS   = 64,
    parameter int IDX_W  = 6,
    parameter int WIDX_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_set,
    output logic [WIDX_W-1:0] rd_way,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_set,
    input  logic [WIDX_W-1:0] upd_way
);
    logic [WIDX_W-1:0] pred_q [SETS];

    // Guess storage: written with the way that hit or was filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) pred_q[s] <= '0;
        end else if (upd_en) begin
            pred_q[upd_set] <= upd_way;
        end
    end

    assign rd_way = pred_q[rd_set];

    // R4: after an update the set's guess is the reported way.
    p_pred_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> pred_q[$past(upd_set)] == $past(upd_way));
endmodule

// File: rtl/wpc_lru.sv
// True LRU order per set by way ages (0 = most recent, WAYS-1 = oldest).
// Picks a victim: the lowest invalid way first, else the oldest.
// Assumes WAYS is a power of two, 2 or more.
module wpc_lru #(
    parameter int WAYS   = 2,
    parameter int SETS   = 64,
    parameter int IDX_W  = 6,
    parameter int WIDX_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              touch_en,
    input  logic [IDX_W-1:0]  touch_set,
    input  logic [WIDX_W-1:0] touch_way,
    input  logic [IDX_W-1:0]  vic_set,
    input  logic [WAYS-1:0]   vic_valid,
    output logic [WIDX_W-1:0] vic_way
);
    logic [WIDX_W-1:0] age_q [SETS][WAYS];
    logic [WAYS-1:0]   zero_vec;
    logic              found;

    // Age update: touched way becomes 0, younger ways age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WIDX_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WIDX_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    // Victim choice: empty way by index, otherwise the oldest way.
    always_comb begin
        vic_way = '0;
        found   = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !vic_valid[w]) begin
                vic_way = WIDX_W'(w);
                found   = 1'b1;
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && age_q[vic_set][w] == WIDX_W'(WAYS - 1)) vic_way = WIDX_W'(w);
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_zero
        assign zero_vec[w] = (age_q[vic_set][w] == '0);
    end

    // R6: exactly one way of a set is the most recently used.
    p_lru_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(zero_vec) == 1);
endmodule

// File: rtl/wpred_cache.sv
// Top: way-predicted set-associative read cache controller.
// Cycle T accepts a request and compares the guessed way; a match answers at T+1.
// Otherwise PROBE1/PROBE2 compare all ways and answer at T+3, or raise a refill.
// Assumes WAYS is 2 or 4 and WORD_W divides the line; the refill side holds no queue.
module wpred_cache #(
    parameter int ADDR_W     = 32,
    parameter int WAYS       = 2,
    parameter int SETS       = 64,
    parameter int LINE_BYTES = 16,
    parameter int WORD_W     = 32,
    parameter int CNT_W      = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    output logic                      req_ready,
    output logic                      resp_valid,
    output logic                      resp_hit,
    output logic [WORD_W-1:0]         resp_data,
    output logic                      refill_req,
    output logic [ADDR_W-1:0]         refill_addr,
    input  logic                      refill_valid,
    input  logic [LINE_BYTES*8-1:0]   refill_line,
    output logic [CNT_W-1:0]          cnt_fast,
    output logic [CNT_W-1:0]          cnt_slow,
    output logic [CNT_W-1:0]          cnt_miss
);
    import wpc_pkg::*;

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W  = LINE_BYTES * 8;
    localparam int WIDX_W  = $clog2(WAYS);
    localparam int WBYTES  = WORD_W / 8;

    wpc_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;
    logic [WIDX_W-1:0] pred_way, hit_way, vic_way, use_way;
    logic              a_hit, any_hit, use_en, fill_en;
    logic [LINE_W-1:0] a_line, b_line;
    logic [WAYS-1:0]   b_hit_vec, b_valid_vec;
    logic [IDX_W-1:0]  req_set, q_set, use_set;
    logic [TAG_W-1:0]  req_tag, q_tag;

    assign req_set   = req_addr[OFF_W +: IDX_W];
    assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
    assign q_set     = addr_q[OFF_W +: IDX_W];
    assign q_tag     = addr_q[ADDR_W-1 -: TAG_W];
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign any_hit   = |b_hit_vec;
    assign refill_req  = (state_q == ST_REFILL);
    assign refill_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign fill_en     = refill_req && refill_valid;

    // Picks the addressed word out of a line.
    function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                    input logic [ADDR_W-1:0] addr);
        int idx;
        idx = int'(addr[OFF_W-1:0]) / WBYTES;
        return line[idx*WORD_W +: WORD_W];
    endfunction

    // Encodes the hitting way of the full compare.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) if (b_hit_vec[w]) hit_way = WIDX_W'(w);
    end

    // Selects the set and way that become most recent and predicted.
    always_comb begin
        use_en  = 1'b0;
        use_set = q_set;
        use_way = hit_way;
        if (accept && a_hit) begin
            use_en  = 1'b1;
            use_set = req_set;
            use_way = pred_way;
        end else if (state_q == ST_PROBE2 && any_hit) begin
            use_en = 1'b1;
        end else if (fill_en) begin
            use_en  = 1'b1;
            use_way = vic_way;
        end
    end

    wpc_way_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W),
                    .IDX_W(IDX_W), .WIDX_W(WIDX_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .a_set(req_set), .a_way(pred_way), .a_tag(req_tag), .a_hit(a_hit), .a_line(a_line),
        .b_set(q_set), .b_tag(q_tag), .b_hit_vec(b_hit_vec), .b_valid_vec(b_valid_vec),
        .b_sel_way(hit_way), .b_line(b_line),
        .wr_en(fill_en), .wr_set(q_set), .wr_way(vic_way), .wr_tag(q_tag), .wr_line(refill_line)
    );

    wpc_pred_table #(.SETS(SETS), .IDX_W(IDX_W), .WIDX_W(WIDX_W)) pred_i (
        .clk(clk), .rst_n(rst_n), .rd_set(req_set), .rd_way(pred_way),
        .upd_en(use_en), .upd_set(use_set), .upd_way(use_way)
    );

    wpc_lru #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .WIDX_W(WIDX_W)) lru_i (
        .clk(clk), .rst_n(rst_n), .touch_en(use_en), .touch_set(use_set), .touch_way(use_way),
        .vic_set(q_set), .vic_valid(b_valid_vec), .vic_way(vic_way)
    );

    // Sequencer: fast answer, two-cycle full compare, or refill wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_data  <= '0;
            cnt_fast   <= '0;
            cnt_slow   <= '0;
            cnt_miss   <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    addr_q <= req_addr;
                    if (a_hit) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b1;
                        resp_data  <= pick_word(a_line, req_addr);
                        cnt_fast   <= cnt_fast + 1'b1;
                    end else begin
                        state_q <= ST_PROBE1;
                    end
                end
                ST_PROBE1: state_q <= ST_PROBE2;
                ST_PROBE2: if (any_hit) begin
                    resp_valid <= 1'b1;
                    resp_hit   <= 1'b1;
                    resp_data  <= pick_word(b_line, addr_q);
                    cnt_slow   <= cnt_slow + 1'b1;
                    state_q    <= ST_IDLE;
                end else begin
                    state_q <= ST_REFILL;
                end
                ST_REFILL: if (refill_valid) begin
                    resp_valid <= 1'b1;
                    resp_hit   <= 1'b0;
                    resp_data  <= pick_word(refill_line, addr_q);
                    cnt_miss   <= cnt_miss + 1'b1;
                    state_q    <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a guessed-way match answers with a hit on the next cycle.
    p_fast_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && a_hit) |=> (resp_valid && resp_hit));
    // R7: a request that missed its guess blocks the next cycle.
    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !a_hit) |=> !req_ready);
    // R5: the refill request holds its address until the line arrives.
    p_refill_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_valid) |=> (refill_req && $stable(refill_addr)));
    // R5: a returned line produces a non-hit response next cycle.
    p_miss_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (resp_valid && !resp_hit));
    // R3: a full-compare hit answers next cycle with the hit flag.
    p_slow_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE2 && any_hit) |=> (resp_valid && resp_hit && req_ready));
endmodule

// File: tb/wpred_cache_tb_top.sv
`timescale 1ns/100ps
module wpred_cache_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_ready, resp_valid, resp_hit, refill_req;
    logic [31:0]  resp_data, refill_addr;
    logic         refill_valid = 1'b0;
    logic [127:0] refill_line = '0;
    logic [15:0]  cnt_fast, cnt_slow, cnt_miss;

    int n_checks = 0;
    int n_fail   = 0;
    int e_fast = 0, e_slow = 0, e_miss = 0;
    bit finished = 1'b0;

    localparam int K_FAST = 1;
    localparam int K_SLOW = 3;
    localparam int K_MISS = 4;

    always #2.5 clk = ~clk;

    wpred_cache dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_data(resp_data), .refill_req(refill_req), .refill_addr(refill_addr),
        .refill_valid(refill_valid), .refill_line(refill_line),
        .cnt_fast(cnt_fast), .cnt_slow(cnt_slow), .cnt_miss(cnt_miss)
    );

    // Records one check and reports a mismatch.
    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int tag, input int set, input int word);
        return (32'(tag) << 10) | (32'(set) << 4) | (32'(word) << 2);
    endfunction

    // Line content returned by the model of the level below.
    function automatic logic [127:0] line_for(input logic [31:0] a);
        logic [127:0] l;
        for (int i = 0; i < 4; i++) l[i*32 +: 32] = {a[31:4], 2'(i), 2'b00} ^ 32'h3C3C_0000;
        return l;
    endfunction

    task automatic chk_counts(input string rq);
        chk(cnt_fast == 16'(e_fast), rq, "cnt_fast", 32'(cnt_fast), 32'(e_fast));
        chk(cnt_slow == 16'(e_slow), rq, "cnt_slow", 32'(cnt_slow), 32'(e_slow));
        chk(cnt_miss == 16'(e_miss), rq, "cnt_miss", 32'(cnt_miss), 32'(e_miss));
    endtask

    // One read with the expected latency class; serves a refill when asked.
    task automatic access(input logic [31:0] a, input int kind, input string rq);
        int  lat = 0;
        bit  served = 1'b0;
        bit  ready_bad = 1'b0;
        logic hit = 1'b0;
        logic [31:0] data = '0;
        logic [31:0] exp_data;
        exp_data = line_for(a)[a[3:2]*32 +: 32];
        @(negedge clk);
        chk(req_ready, "R7", "ready before request", 32'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 1; n < 40 && lat == 0; n++) begin
            if (resp_valid) begin
                lat = n; hit = resp_hit; data = resp_data;
                chk(req_ready, "R7", "ready in response cycle", 32'(req_ready), 1);
            end else begin
                if (req_ready) ready_bad = 1'b1;
                if (refill_req && !served) begin
                    chk(refill_addr == {a[31:4], 4'h0}, "R5", "refill_addr",
                        refill_addr, {a[31:4], 4'h0});
                    chk(n == 3, "R5", "refill_req cycle", 32'(n), 3);
                    refill_valid = 1'b1;
                    refill_line  = line_for(a);
                    served = 1'b1;
                end else begin
                    refill_valid = 1'b0;
                end
                @(negedge clk);
            end
        end
        refill_valid = 1'b0;
        if (kind != K_FAST)
            chk(!ready_bad, "R7", "ready low while busy", 32'(ready_bad), 0);
        if (kind == K_FAST) e_fast++;
        if (kind == K_SLOW) e_slow++;
        if (kind == K_MISS) e_miss++;
        chk(lat == kind, rq, "latency", 32'(lat), 32'(kind));
        chk(hit == (kind != K_MISS), rq, "resp_hit", 32'(hit), 32'(kind != K_MISS));
        chk(data == exp_data, "R9", "resp_data", data, exp_data);
        chk_counts(rq);
    endtask

    // R8: slow hit, then the same address issued in its response cycle.
    task automatic back_to_back(input logic [31:0] a);
        logic [31:0] exp_data;
        exp_data = line_for(a)[a[3:2]*32 +: 32];
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(resp_valid && resp_hit, "R3", "slow hit at cycle 3", 32'(resp_valid), 1);
        chk(req_ready, "R8", "ready in response cycle", 32'(req_ready), 1);
        e_slow++;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid && resp_hit, "R8", "follow-on fast hit", 32'(resp_valid), 1);
        chk(resp_data == exp_data, "R8", "follow-on data", resp_data, exp_data);
        e_fast++;
        chk_counts("R8");
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
        chk(!resp_valid, "R1", "resp_valid after reset", 32'(resp_valid), 0);
        chk(!refill_req, "R1", "refill_req after reset", 32'(refill_req), 0);
        chk_counts("R1");
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, c, p, q, far;
        a   = mk(1, 5, 2);
        b   = mk(2, 5, 1);
        c   = mk(3, 5, 3);
        p   = mk(4, 7, 0);
        q   = mk(5, 7, 1);
        far = mk(1, 9, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        access(a, K_MISS, "R1");        // first access after reset misses, fills way 0
        access(a, K_FAST, "R6");        // prediction set to filled way
        access(b, K_MISS, "R5");        // fills empty way 1
        access(b, K_FAST, "R2");
        access(a, K_SLOW, "R3");        // guess is way 1, line in way 0
        access(a, K_FAST, "R4");        // guess now follows the hit
        access(c, K_MISS, "R6");        // evicts b (least recent)
        access(c, K_FAST, "R2");
        access(b, K_MISS, "R6");        // b was evicted; evicts a
        access(a, K_MISS, "R6");        // a was evicted; evicts c
        access(b, K_SLOW, "R6");        // b survived in way 0, guess points at a
        access(far, K_MISS, "R10");     // same tag as a, other set
        access(a, K_SLOW, "R10");       // set 5 guess untouched by set 9
        access(mk(1, 5, 0), K_FAST, "R9");
        access(mk(1, 5, 3), K_FAST, "R9");
        access(p, K_MISS, "R5");
        access(q, K_MISS, "R5");
        back_to_back(p);
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule